// File: doc/BRIEF.md
# Mode-Decoding One-Time-Programmable Byte Memory

This block is a synchronous behavioural model of a byte-wide programmable read-only memory, meant to stand in for a boot or calibration store inside a larger design. Four control inputs select what it does on each clock. These are an active-low chip select, an active-low output gate, a flag that says the programming supply is present, and a flag that says the high identification voltage is on address line 9. In every clock cycle the decoder places the block in one of seven modes:

- Standby: chip select high, no programming supply.
- Inhibit: chip select high while the programming supply is present.
- Output-off: chip select low, gate high.
- Read: chip select low, gate low.
- Signature: as Read, with the identification flag set.
- Program: chip select low, gate high, programming supply present.
- Verify: chip select low, gate low, programming supply present.

The data bus is split into `din`, `dout` and the registered bus-drive enable `dout_en`. A program pulse is a run of Program cycles. It is closed by chip select rising while the supply stays present, and the byte then written is the old content ANDed with the new byte, so bits only ever move toward zero. A bulk-erase input, or reset, sets every byte back to all ones.

The program sequencer has three states. PG_IDLE moves to PG_ARMED on a Program cycle. PG_ARMED captures address and data on every Program cycle. It moves to PG_COMMIT when the mode becomes Inhibit, which is the rising edge of chip select, and falls back to PG_IDLE on any other mode, which aborts the pulse. PG_COMMIT performs the write for one cycle. From there it moves to PG_ARMED if the next cycle is Program again, and to PG_IDLE otherwise. The full-size instance uses `ADDR_W = 16` for 65,536 bytes. The default is kept smaller for elaboration.

Top module: `otp_mode_mem`

## Requirements
- R1: After reset, and in the cycle after `erase` is high, every byte reads 0xFF.
- R2: In Read mode (ce_n=0, oe_n=0, vpp_on=0, a9_hv=0), `dout_en` is 1 and `dout` is the byte at `addr` one clock after the inputs are sampled.
- R3: While ce_n=1, `dout_en` and `dout` are 0 in the next cycle, whatever oe_n, vpp_on and a9_hv are.
- R4: In Output-off mode (ce_n=0, oe_n=1, vpp_on=0), `dout_en` and `dout` are 0 in the next cycle, with or without a9_hv.
- R5: A Program pulse (vpp_on=1, ce_n=0, oe_n=1) followed by a cycle with ce_n=1 and vpp_on=1 writes the captured `din` to the captured `addr`. The bus is not driven during the pulse.
- R6: A write stores the old byte AND `din`. A second write to a location can clear further bits but never set one.
- R7: With ce_n=1 and vpp_on=1 held from idle nothing is written. A pulse that ends in any mode other than Inhibit (for example, vpp_on dropped first) writes nothing.
- R8: In Verify mode (vpp_on=1, ce_n=0, oe_n=0), `dout_en` is 1 and `dout` is the stored byte one clock later.
- R9: In Signature mode (a9_hv=1, ce_n=0, oe_n=0, vpp_on=0), `dout` is 0x20 when addr[0]=0 and 0x3D when addr[0]=1. The other address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | Identification voltage present on address line 9 |
| erase | input | 1 | Synchronous bulk erase to all ones |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Registered read data, zero when not driven |
| dout_en | output | 1 | Registered bus-drive enable |

## Verification
The hardest case to reach is an AND-merge onto a byte that was already programmed. The stimulus first programs every location with one computed pattern, then programs every location again with a second pattern, and compares each byte with the AND of both. Aborted pulses are reached by dropping the supply flag while a pulse is still open. Inhibit cycles are entered straight from idle, and the bench then reads the target byte back to show it is unchanged.

// File: rtl/otp_mode_pkg.sv
package otp_mode_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_OUT_OFF,
        MD_READ,
        MD_SIGNATURE,
        MD_PROGRAM,
        MD_VERIFY
    } mode_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_ARMED,
        PG_COMMIT
    } pg_state_e;

    localparam logic [7:0] ID_BYTE_LO = 8'h20;
    localparam logic [7:0] ID_BYTE_HI = 8'h3D;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_mode_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_on,
    input  logic  a9_hv,
    output mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
        end else if (vpp_on) begin
            mode = oe_n ? MD_PROGRAM : MD_VERIFY;
        end else if (oe_n) begin
            mode = MD_OUT_OFF;
        end else begin
            mode = a9_hv ? MD_SIGNATURE : MD_READ;
        end
    end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_mode_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    pg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:   if (mode_i == MD_PROGRAM) state_d = PG_ARMED;
            PG_ARMED:  begin
                if (mode_i == MD_INHIBIT)      state_d = PG_COMMIT;
                else if (mode_i != MD_PROGRAM) state_d = PG_IDLE;
            end
            PG_COMMIT: state_d = (mode_i == MD_PROGRAM) ? PG_ARMED : PG_IDLE;
            default:   state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '1;
        end else if (mode_i == MD_PROGRAM) begin
            wr_addr <= addr_i;
            wr_data <= data_i;
        end
    end

    assign wr_en = (state_q == PG_COMMIT);

    // R5
    commit_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_COMMIT) |-> ($past(state_q) == PG_ARMED && $past(mode_i) == MD_INHIBIT));

    // R7
    no_commit_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PG_IDLE) |-> (state_q != PG_COMMIT));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

    // R6
    and_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> (cells[$past(wr_addr)] == $past(cells[wr_addr] & wr_data)));

endmodule

// File: rtl/otp_mode_mem.sv
module otp_mode_mem
    import otp_mode_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    mode_e             mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] id_byte;

    otp_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_on (vpp_on),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    otp_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .addr_i  (addr),
        .data_i  (din),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    assign id_byte = addr[0] ? DATA_W'(ID_BYTE_HI) : DATA_W'(ID_BYTE_LO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            unique case (mode)
                MD_READ, MD_VERIFY: begin
                    dout    <= rd_data;
                    dout_en <= 1'b1;
                end
                MD_SIGNATURE: begin
                    dout    <= id_byte;
                    dout_en <= 1'b1;
                end
                default: begin
                    dout    <= '0;
                    dout_en <= 1'b0;
                end
            endcase
        end
    end

    // R3
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en);

    // R4
    gate_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n));

    // R9
    signature_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !oe_n && !vpp_on && a9_hv) |->
            (dout == ($past(addr[0]) ? DATA_W'(ID_BYTE_HI) : DATA_W'(ID_BYTE_LO))));

endmodule

// File: tb/otp_mode_mem_tb.sv
module otp_mode_mem_tb_top;

    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, oe_n, vpp_on, a9_hv, erase;
    logic [AW-1:0] addr;
    logic [7:0]    din, dout;
    logic          dout_en;
    int            errs = 0;
    int            checks = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    otp_mode_mem #(.ADDR_W(AW), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
        .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] pat1(int a);
        return 8'(a * 37 + 5);
    endfunction

    function automatic logic [7:0] pat2(int a);
        return 8'(a * 91) ^ 8'h5A;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic c, logic o, logic v, logic h, int a, logic [7:0] d);
        ce_n = c; oe_n = o; vpp_on = v; a9_hv = h; addr = AW'(a); din = d;
    endtask

    task automatic chk(string req, logic en_exp, logic [7:0] d_exp);
        checks++;
        if (dout_en !== en_exp || dout !== d_exp) begin
            errs++;
            $display("FAIL %s: act en=%0b dout=%02h exp en=%0b dout=%02h",
                     req, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic read_chk(int a, logic [7:0] exp, string req);
        drive(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        step();
        chk(req, 1'b1, exp);
    endtask

    task automatic program_byte(int a, logic [7:0] d);
        drive(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        step();
        chk("R5 bus floats in program", 1'b0, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 1'b0, a, d);
        step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
        step();
        step();
    endtask

    initial begin
        rst_n = 1'b0; erase = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R3 reset state", 1'b0, 8'h00);

        for (int a = 0; a < N; a++) read_chk(a, 8'hFF, "R1 after reset");

        for (int i = 0; i < 8; i++) begin
            drive(1'b1, i[0], i[1], i[2], i * 7, 8'h00);
            step();
            chk("R3 standby", 1'b0, 8'h00);
        end

        for (int h = 0; h < 2; h++) begin
            drive(1'b0, 1'b1, 1'b0, h[0], 3, 8'h00);
            step();
            chk("R4 output off", 1'b0, 8'h00);
        end

        for (int a = 0; a < N; a++) program_byte(a, pat1(a));
        for (int a = 0; a < N; a++) read_chk(a, pat1(a), "R2 R5 first write");

        for (int a = 0; a < N; a++) program_byte(a, pat2(a));
        for (int a = 0; a < N; a++) read_chk(a, pat1(a) & pat2(a), "R6 and-merge");

        for (int a = 0; a < 8; a++) begin
            drive(1'b0, 1'b0, 1'b1, 1'b0, a * 5, 8'h00);
            step();
            chk("R8 verify", 1'b1, pat1(a * 5) & pat2(a * 5));
        end

        for (int i = 0; i < 16; i++) begin
            int a = (i * 13 + i) % N;
            drive(1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00);
            step();
            chk("R9 signature", 1'b1, a[0] ? 8'h3D : 8'h20);
        end

        drive(1'b1, 1'b1, 1'b1, 1'b0, 5, 8'h00);
        repeat (4) step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
        step();
        read_chk(5, pat1(5) & pat2(5), "R7 inhibit from idle");

        drive(1'b0, 1'b1, 1'b1, 1'b0, 9, 8'h00);
        step();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9, 8'h00);
        step();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 9, 8'h00);
        repeat (2) step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
        step();
        read_chk(9, pat1(9) & pat2(9), "R7 aborted pulse");

        erase = 1'b1;
        step();
        erase = 1'b0;
        for (int a = 0; a < N; a++) read_chk(a, 8'hFF, "R1 after erase");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog (all requirements): act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule